// File: doc/BRIEF.md
# Downstream Port Reset and Chirp Sequencer

This block controls one downstream port of a USB 2.0 hub while the port is reset and its speed is negotiated. It watches the sampled line state to see when a device attaches or leaves. When it gets a reset command for an attached port, it drives SE0 for a programmed number of timebase ticks. The length is clamped to a legal window.

While SE0 is driven, the block looks for a device chirp K. The chirp counts only after it has been seen for a minimum hold time. After a qualified chirp ends, the block answers at once with hub chirps. The chirps alternate K and J, and each lasts a fixed number of ticks. A new chirp starts only when it can finish and still leave a guard gap before the reset ends. When the reset ends, the port drive is released and a one-cycle done pulse carries the negotiated speed. If no device chirp was qualified, the speed is low or full, taken from the idle line state seen when the command arrived.

All timing counts `tick` strobes, so the same logic runs from any timebase. With the default parameters one tick is 0.5 µs: the hold time is 2.5 µs, the disconnect time is 2.0 µs, each chirp is 50 µs, the guard is 200 µs and the reset length is 10 to 20 ms.

Top module: `dsport_reset_seq`

## Requirements
- R1: After reset the port reads unconnected, with `drv_en`, `conn` and `done` low.
- R2: While unconnected, `conn` rises once the line has held J (code 01) or K (code 10) for FILT_TK consecutive ticks. A shorter J or K followed by SE0 (code 00) leaves `conn` low.
- R3: While connected and idle, `conn` falls after the line holds SE0 for DISC_TK consecutive ticks. A shorter SE0 has no effect.
- R4: A `rst_cmd` pulse on a connected, idle port drives SE0 (`drv_en`=1, `drv_st`=00) for exactly N ticks. N is `rst_len` clamped to the range [RST_MIN_TK, RST_MAX_TK].
- R5: `rst_cmd` is ignored while the port is unconnected and while a reset is already running. An ignored command changes neither the drive nor the reset length.
- R6: During the reset, a device chirp K qualifies only after FILT_TK consecutive ticks of K. A shorter K leaves the negotiated speed at full or low.
- R7: After a qualified device chirp ends, the hub drive turns to K (code 10) in the next cycle. Hub chirps then alternate K and J (code 01), each lasting exactly CHIRP_TK ticks, with the first one always K.
- R8: A hub chirp starts only if it ends at least GUARD_TK ticks before the reset ends. After the last chirp, SE0 is driven for between GUARD_TK and GUARD_TK+CHIRP_TK-1 ticks. If the device chirp ends too late, no hub chirp is sent and the speed stays full or low.
- R9: When the reset ends, `drv_en` falls and `done` pulses for one cycle. `speed` then reads 10 if the hub chirped, 01 if the idle line was J at command time, or 00 if it was K.
- R10: If `env_disc` stays high for DISC_TK consecutive ticks during a reset, the reset is aborted. `drv_en` and `conn` fall together and `done` is not raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe; every timer counts these |
| line_st | input | 2 | Sampled line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| env_disc | input | 1 | Receiver sees the device termination gone; used while the port is driven |
| rst_cmd | input | 1 | Single-cycle request to reset the port |
| rst_len | input | LW | Requested reset length in ticks, sampled with `rst_cmd` |
| drv_en | output | 1 | Port transmitter enabled |
| drv_st | output | 2 | Line state to drive, same coding as `line_st` |
| conn | output | 1 | Device connected |
| done | output | 1 | One-cycle pulse at the end of a completed reset |
| speed | output | 2 | Negotiated speed: 00 low, 01 full, 10 high |

## Verification
The assertions assume that `rst_cmd` is a single-cycle pulse and that `line_st` and `env_disc` change only between clock edges. They also assume that a disconnect during a reset shows up on `env_disc`, not as SE0 on `line_st`. The stimulus holds `tick` high every cycle, so tick counts equal cycle counts, and changes every input on the falling clock edge. It plays device chirps only inside the SE0 window, and it returns the line to its idle J or K before the port goes back to idle.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        SPD_LOW  = 2'b00,
        SPD_FULL = 2'b01,
        SPD_HIGH = 2'b10
    } speed_e;

    typedef enum logic [2:0] {
        SQ_UNPLUGGED = 3'd0,
        SQ_READY     = 3'd1,
        SQ_RESET     = 3'd2,
        SQ_DEVCHIRP  = 3'd3,
        SQ_HUBCHIRP  = 3'd4,
        SQ_TAIL      = 3'd5
    } seq_state_e;

endpackage

// File: rtl/dps_hold_cnt.sv
// Counts ticks while a condition holds continuously; sticks at the limit.
module dps_hold_cnt #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!match) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == LIM);

endmodule

// File: rtl/dps_len_clamp.sv
// Limits a requested reset length to the legal window.
module dps_len_clamp #(
    parameter int LW      = 16,
    parameter int MIN_LEN = 20000,
    parameter int MAX_LEN = 40000
) (
    input  logic [LW-1:0] req_len,
    output logic [LW-1:0] use_len
);
    localparam logic [LW-1:0] LO = LW'(MIN_LEN);
    localparam logic [LW-1:0] HI = LW'(MAX_LEN);

    always_comb begin
        if (req_len < LO) begin
            use_len = LO;
        end else if (req_len > HI) begin
            use_len = HI;
        end else begin
            use_len = req_len;
        end
    end

endmodule

// File: rtl/dsport_reset_seq.sv
module dsport_reset_seq
    import dps_pkg::*;
#(
    parameter int FILT_TK    = 5,
    parameter int DISC_TK    = 4,
    parameter int CHIRP_TK   = 100,
    parameter int GUARD_TK   = 400,
    parameter int RST_MIN_TK = 20000,
    parameter int RST_MAX_TK = 40000,
    localparam int LW        = $clog2(RST_MAX_TK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    line_st,
    input  logic          env_disc,
    input  logic          rst_cmd,
    input  logic [LW-1:0] rst_len,
    output logic          drv_en,
    output logic [1:0]    drv_st,
    output logic          conn,
    output logic          done,
    output logic [1:0]    speed
);
    localparam int CTW = $clog2(CHIRP_TK + 1);
    localparam logic [CTW-1:0] CHIRP_END = CTW'(CHIRP_TK);
    localparam int SPAN = CHIRP_TK + GUARD_TK;

    typedef struct packed {
        seq_state_e     st;
        logic [LW-1:0]  rt;
        logic [LW-1:0]  len;
        logic [CTW-1:0] ct;
        logic           kj;
        logic [1:0]     spd;
        logic           conn;
        logic           done;
    } seq_t;

    seq_t q, d;

    logic           in_reset;
    logic           attach_hit, gone_hit, chirp_hit;
    logic           attach_m, gone_m, chirp_m;
    logic [LW-1:0]  len_c;
    logic [LW-1:0]  rt_inc;
    logic [CTW-1:0] ct_inc;
    logic           room;

    assign in_reset = (q.st == SQ_RESET) || (q.st == SQ_DEVCHIRP) ||
                      (q.st == SQ_HUBCHIRP) || (q.st == SQ_TAIL);

    assign attach_m = (q.st == SQ_UNPLUGGED) &&
                      ((line_st == LS_J) || (line_st == LS_K));
    assign gone_m   = in_reset ? env_disc :
                      ((q.st == SQ_READY) && (line_st == LS_SE0));
    assign chirp_m  = (q.st == SQ_RESET) && (line_st == LS_K);

    dps_hold_cnt #(.LIMIT(FILT_TK)) u_attach (
        .clk(clk), .rst_n(rst_n), .tick(tick), .match(attach_m), .hit(attach_hit)
    );
    dps_hold_cnt #(.LIMIT(DISC_TK)) u_gone (
        .clk(clk), .rst_n(rst_n), .tick(tick), .match(gone_m), .hit(gone_hit)
    );
    dps_hold_cnt #(.LIMIT(FILT_TK)) u_chirp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .match(chirp_m), .hit(chirp_hit)
    );

    dps_len_clamp #(.LW(LW), .MIN_LEN(RST_MIN_TK), .MAX_LEN(RST_MAX_TK)) u_clamp (
        .req_len(rst_len), .use_len(len_c)
    );

    assign rt_inc = q.rt + 1'b1;
    assign ct_inc = q.ct + 1'b1;
    // A new chirp may start only if it finishes a full guard before reset end.
    assign room   = (32'(rt_inc) + 32'(SPAN)) <= 32'(q.len);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            SQ_UNPLUGGED: begin
                if (attach_hit) begin
                    d.st   = SQ_READY;
                    d.conn = 1'b1;
                end
            end
            SQ_READY: begin
                if (gone_hit) begin
                    d.st   = SQ_UNPLUGGED;
                    d.conn = 1'b0;
                end else if (rst_cmd) begin
                    d.st  = SQ_RESET;
                    d.rt  = '0;
                    d.len = len_c;
                    d.spd = (line_st == LS_K) ? SPD_LOW : SPD_FULL;
                end
            end
            default: begin
                if (gone_hit) begin
                    d.st   = SQ_UNPLUGGED;
                    d.conn = 1'b0;
                end else if (tick && (rt_inc >= q.len)) begin
                    d.st   = SQ_READY;
                    d.done = 1'b1;
                end else begin
                    if (tick) begin
                        d.rt = rt_inc;
                    end
                    case (q.st)
                        SQ_RESET: begin
                            if (chirp_hit) begin
                                d.st = SQ_DEVCHIRP;
                            end
                        end
                        SQ_DEVCHIRP: begin
                            if (line_st != LS_K) begin
                                if (room) begin
                                    d.st  = SQ_HUBCHIRP;
                                    d.ct  = '0;
                                    d.kj  = 1'b0;
                                    d.spd = SPD_HIGH;
                                end else begin
                                    d.st = SQ_TAIL;
                                end
                            end
                        end
                        SQ_HUBCHIRP: begin
                            if (tick) begin
                                if (ct_inc == CHIRP_END) begin
                                    if (room) begin
                                        d.ct = '0;
                                        d.kj = ~q.kj;
                                    end else begin
                                        d.st = SQ_TAIL;
                                    end
                                end else begin
                                    d.ct = ct_inc;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign drv_en = in_reset;
    assign drv_st = (q.st == SQ_HUBCHIRP) ? (q.kj ? LS_J : LS_K) : LS_SE0;
    assign conn   = q.conn;
    assign done   = q.done;
    assign speed  = q.spd;

endmodule

// File: rtl/dsport_reset_seq_chk.sv
module dsport_reset_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       drv_en,
    input logic [1:0] drv_st,
    input logic       conn,
    input logic       done,
    input logic [1:0] speed
);
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> (done || !conn));

    a_r9_speed_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (speed != 2'b11));

    a_r5_no_drive_unplugged: assert property (@(posedge clk) disable iff (!rst_n)
        !conn |-> !drv_en);

    a_r7_first_chirp_is_k: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && $past(drv_en) && ($past(drv_st) == 2'b00) && (drv_st != 2'b00))
        |-> (drv_st == 2'b10));

    a_r10_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conn) |-> (!drv_en && !done));

endmodule

bind dsport_reset_seq dsport_reset_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_st(drv_st),
    .conn(conn), .done(done), .speed(speed)
);

// File: tb/dsport_reset_seq_tb_top.sv
module dsport_reset_seq_tb_top;
    localparam int FILT  = 5;
    localparam int DISC  = 4;
    localparam int CHIRP = 20;
    localparam int GUARD = 40;
    localparam int RMIN  = 300;
    localparam int RMAX  = 600;
    localparam int LW    = $clog2(RMAX + 1);

    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] JST = 2'b01;
    localparam logic [1:0] KST = 2'b10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic [1:0]    line_st = SE0;
    logic          env_disc = 1'b0;
    logic          rst_cmd = 1'b0;
    logic [LW-1:0] rst_len = '0;
    logic          drv_en;
    logic [1:0]    drv_st;
    logic          conn;
    logic          done;
    logic [1:0]    speed;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;
    logic [1:0] idle_ls = JST;

    int r_drv, r_first, r_nseg, r_badseg, r_tail;
    logic [1:0] r_first_val, r_spd;
    bit r_done, r_chirped;

    always #5 clk = ~clk;

    dsport_reset_seq #(
        .FILT_TK(FILT), .DISC_TK(DISC), .CHIRP_TK(CHIRP), .GUARD_TK(GUARD),
        .RST_MIN_TK(RMIN), .RST_MAX_TK(RMAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_st(line_st),
        .env_disc(env_disc), .rst_cmd(rst_cmd), .rst_len(rst_len),
        .drv_en(drv_en), .drv_st(drv_st), .conn(conn), .done(done), .speed(speed)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_reset(input int len, input int ks, input int kl,
                             input int disc_at, input int cmd2_at);
        logic [1:0] prev;
        int seg;
        r_drv = 0; r_first = -1; r_nseg = 0; r_badseg = 0; r_tail = 0;
        r_first_val = SE0; r_spd = 2'b11; r_done = 1'b0; r_chirped = 1'b0;
        prev = SE0; seg = 0;
        @(negedge clk);
        rst_cmd = 1'b1;
        rst_len = LW'(len);
        @(negedge clk);
        rst_cmd = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (drv_en) begin
                r_drv++;
                if (drv_st != SE0) begin
                    if (r_first < 0) begin
                        r_first = i;
                        r_first_val = drv_st;
                    end
                    if (drv_st == 2'b11) r_badseg++;
                    if (drv_st == prev) begin
                        seg++;
                    end else begin
                        if (prev != SE0) begin
                            r_nseg++;
                            if (seg != CHIRP) r_badseg++;
                        end
                        seg = 1;
                    end
                    r_tail = 0;
                    r_chirped = 1'b1;
                end else begin
                    if (prev != SE0) begin
                        r_nseg++;
                        if (seg != CHIRP) r_badseg++;
                        seg = 0;
                    end
                    r_tail++;
                end
                prev = drv_st;
            end
            if (done) begin
                r_done = 1'b1;
                r_spd = speed;
                break;
            end
            if (disc_at >= 0 && i > disc_at && !conn && !drv_en) break;
            rst_cmd  = (i == cmd2_at);
            rst_len  = (i == cmd2_at) ? LW'(RMAX) : rst_len;
            line_st  = (ks >= 0 && i >= ks && i < ks + kl) ? KST : SE0;
            env_disc = (disc_at >= 0 && i >= disc_at);
            @(negedge clk);
        end
        rst_cmd = 1'b0;
        env_disc = 1'b0;
        line_st = idle_ls;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state;
        chk(!drv_en, "R1 drv_en after reset", drv_en, 0);
        chk(!conn, "R1 conn after reset", conn, 0);
        chk(!done, "R1 done after reset", done, 0);
    endtask

    task automatic t_connect;
        line_st = JST;
        repeat (3) @(negedge clk);
        line_st = SE0;
        repeat (10) @(negedge clk);
        chk(!conn, "R2 short J ignored", conn, 0);
        line_st = JST;
        repeat (10) @(negedge clk);
        chk(conn, "R2 held J connects", conn, 1);
    endtask

    task automatic t_disconnect;
        line_st = SE0;
        repeat (2) @(negedge clk);
        line_st = JST;
        repeat (10) @(negedge clk);
        chk(conn, "R3 short SE0 ignored", conn, 1);
        line_st = SE0;
        repeat (10) @(negedge clk);
        chk(!conn, "R3 held SE0 disconnects", conn, 0);
    endtask

    task automatic t_cmd_unplugged;
        int seen = 0;
        @(negedge clk);
        rst_cmd = 1'b1;
        rst_len = LW'(400);
        @(negedge clk);
        rst_cmd = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (drv_en) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R5 command ignored while unplugged", seen, 0);
        line_st = JST;
        repeat (10) @(negedge clk);
        chk(conn, "R2 reconnect", conn, 1);
    endtask

    task automatic t_full_speed;
        run_reset(400, -1, 0, -1, -1);
        chk(r_drv == 400, "R4 SE0 length", r_drv, 400);
        chk(r_done, "R9 done raised", r_done, 1);
        chk(r_spd == 2'b01, "R9 full speed code", r_spd, 1);
        chk(!r_chirped, "R6 no hub chirp without device chirp", r_chirped, 0);
        chk(!drv_en && conn, "R9 port released and connected", drv_en, 0);
    endtask

    task automatic t_clamp;
        run_reset(10, -1, 0, -1, -1);
        chk(r_drv == RMIN, "R4 clamp to minimum", r_drv, RMIN);
        run_reset(1000, -1, 0, -1, -1);
        chk(r_drv == RMAX, "R4 clamp to maximum", r_drv, RMAX);
    endtask

    task automatic t_second_cmd;
        run_reset(300, -1, 0, -1, 50);
        chk(r_drv == 300, "R5 command during reset ignored", r_drv, 300);
    endtask

    task automatic t_short_chirp;
        run_reset(400, 30, FILT - 1, -1, -1);
        chk(!r_chirped, "R6 short device K not answered", r_chirped, 0);
        chk(r_spd == 2'b01, "R6 short K keeps full speed", r_spd, 1);
    endtask

    task automatic t_high_speed(input int kl);
        int ks = 20;
        run_reset(400, ks, kl, -1, -1);
        chk(r_spd == 2'b10, "R9 high speed code", r_spd, 2);
        chk(r_first_val == KST, "R7 first hub chirp is K", r_first_val, KST);
        if (kl > FILT) begin
            chk(r_first == ks + kl + 1, "R7 response latency", r_first, ks + kl + 1);
        end else begin
            chk(r_first >= 0, "R6 minimum device K qualifies", r_first, ks + kl + 2);
        end
        chk(r_badseg == 0, "R7 chirp lengths and alternation", r_badseg, 0);
        chk(r_nseg >= 2, "R7 several chirps sent", r_nseg, 2);
        chk(r_tail >= GUARD && r_tail < GUARD + CHIRP, "R8 guard before reset end",
            r_tail, GUARD);
        chk(r_drv == 400, "R4 length with chirps", r_drv, 400);
    endtask

    task automatic t_late_chirp;
        run_reset(300, 250, 10, -1, -1);
        chk(!r_chirped, "R8 no room for hub chirp", r_chirped, 0);
        chk(r_spd == 2'b01, "R8 late chirp stays full speed", r_spd, 1);
    endtask

    task automatic t_low_speed;
        idle_ls = KST;
        line_st = KST;
        repeat (3) @(negedge clk);
        run_reset(300, -1, 0, -1, -1);
        chk(r_spd == 2'b00, "R9 low speed code", r_spd, 0);
        idle_ls = JST;
        line_st = JST;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_abort;
        run_reset(400, -1, 0, 100, -1);
        chk(!r_done, "R10 no done after abort", r_done, 0);
        chk(!conn, "R10 disconnected after abort", conn, 0);
        chk(!drv_en, "R10 drive released after abort", drv_en, 0);
        chk(r_drv > 100 && r_drv < 110, "R10 abort timing", r_drv, 100 + DISC);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_connect();
        t_disconnect();
        t_cmd_unplugged();
        t_full_speed();
        t_clamp();
        t_second_cmd();
        t_short_chirp();
        t_high_speed(10);
        t_high_speed(FILT);
        t_late_chirp();
        t_low_speed();
        t_abort();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        fin = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule